// File: doc/BRIEF.md
# Multi-Link Sync Point Controller

This block produces a periodic sync-point strobe. A reloading down-counter, clocked by the reference oscillator, generates it. The strobe marks the instant at which command and audio changes can be made safely, and up to four serial links share it. At a 4 kHz sync rate the period value is 5999 for a 24 MHz reference and 9599 for a 38.4 MHz reference.

Software loads a new period together with a handshake flag. The new period is applied only when hardware clears that flag, which happens once at least one link is active. Bank switches are staged per link. A single go flag launches all staged links together, so every link that asked for a switch gets its one-cycle bank-switch pulse on the same sync point.

Each link also has a power request bit. Its acknowledge bit follows the request after a fixed settling delay, so software can poll it. An acknowledged link counts as active.

Top module: `sync_point_ctrl`

## Requirements
- R1: After reset, both registers read zero, `bank_switch` and `link_active` are zero, and `sync_pulse` is high on every cycle because the applied period is zero.
- R2: `sync_pulse` is high for one cycle every P+1 clocks, where P is the applied period.
- R3: A write to the sync register (`reg_sel`=0) with bit 15 set loads bits 14:0 into the period field and sets the handshake bit 15. A write with bit 15 clear changes neither the period field nor bit 15.
- R4: The period field is applied only when hardware clears the handshake bit. This happens one cycle after the bit is seen set while any link is active. Until then the sync rate is unchanged and bit 15 reads one.
- R5: Writing a one to bit 16+n of the sync register stages a bank switch for link n. Zero bits have no effect. Staged bits read back at 19:16.
- R6: Writing a one to bit 24 of the sync register sets the go flag when at least one staged bit is set after that write. Go then reads one until the launch.
- R7: On the first `sync_pulse` cycle with go set, `bank_switch` equals the staged mask for exactly that cycle. After it, the staged bits and go read zero.
- R8: Writing go while nothing is staged has no effect: bit 24 reads zero and no `bank_switch` pulse occurs.
- R9: In the link register (`reg_sel`=1), bit n is the read/write power request of link n. Bit 8+n is the read-only acknowledge, which takes the request's value 16 clocks after the request changes.
- R10: `link_active` bit n equals the acknowledge bit of link n.
- R11: If a request returns to its acknowledged value before the delay runs out, the acknowledge does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the sync register, 1 the link register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| sync_pulse | output | 1 | One-cycle sync point strobe |
| bank_switch | output | NUM_LINKS | Per-link bank-switch pulse |
| link_active | output | NUM_LINKS | Acknowledged power state per link |

## Verification
The period path is tried with period writes that omit the handshake, with handshake writes made while no link is active, and with random periods applied while a link is up. Together these separate a period that is loaded from one that is actually applied. Launches are tried with an empty mask, with a directed two-link mask and with random masks. This catches a missing launch, a launch outside a sync point, and staged bits that are not cleared. Power requests are tried with full toggles on random links and with a request withdrawn midway, which pins down the exact 16-cycle delay and the restart rule.

// File: rtl/syncpt_pkg.sv
package syncpt_pkg;

  // register select values
  localparam logic SEL_SYNC = 1'b0;
  localparam logic SEL_LINK = 1'b1;

  // bit positions inside the sync register
  localparam int unsigned HS_BIT    = 15;
  localparam int unsigned STAGE_LSB = 16;
  localparam int unsigned GO_BIT    = 24;

  // bit position of the first acknowledge bit in the link register
  localparam int unsigned ACK_LSB   = 8;

  // clocks between two sync points for a given period value
  function automatic logic [31:0] interval_of(input logic [31:0] period);
    return period + 32'd1;
  endfunction

  // assembles the sync register read value
  function automatic logic [31:0] pack_sync(input logic [31:0] period,
                                            input logic        hs,
                                            input logic [7:0]  staged,
                                            input logic        go);
    logic [31:0] w;
    w                    = period & 32'h0000_7FFF;
    w[HS_BIT]            = hs;
    w[STAGE_LSB +: 8]    = staged;
    w[GO_BIT]            = go;
    return w;
  endfunction

endpackage

// File: rtl/syncpt_period_timer.sv
module syncpt_period_timer #(
  parameter int PERIOD_W = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hs_wr,
  input  logic [PERIOD_W-1:0] wr_period,
  input  logic                any_active,
  output logic [PERIOD_W-1:0] period_q,
  output logic                hs_q,
  output logic [PERIOD_W-1:0] active_period,
  output logic                sync_pulse,
  output logic                commit_ev
);

  logic [PERIOD_W-1:0] cnt_q;

  // handshake completes when a link is active and no new load races it
  assign commit_ev  = hs_q && any_active && !hs_wr;
  assign sync_pulse = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      hs_q     <= 1'b0;
    end else if (hs_wr) begin
      period_q <= wr_period;
      hs_q     <= 1'b1;
    end else if (commit_ev) begin
      hs_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_period <= '0;
      cnt_q         <= '0;
    end else if (commit_ev) begin
      active_period <= period_q;
      cnt_q         <= period_q;
    end else if (sync_pulse) begin
      cnt_q         <= active_period;
    end else begin
      cnt_q         <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/syncpt_bank_stager.sv
module syncpt_bank_stager #(
  parameter int NUM_LINKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINKS-1:0] stage_set,
  input  logic                 go_wr,
  input  logic                 sync_pulse,
  output logic [NUM_LINKS-1:0] staged_q,
  output logic                 go_q,
  output logic [NUM_LINKS-1:0] bank_switch,
  output logic                 fire_ev
);

  logic [NUM_LINKS-1:0] staged_nxt;

  assign fire_ev     = go_q && sync_pulse;
  assign bank_switch = fire_ev ? staged_q : '0;

  always_comb begin
    staged_nxt = fire_ev ? '0 : staged_q;
    staged_nxt = staged_nxt | stage_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged_q <= '0;
      go_q     <= 1'b0;
    end else begin
      staged_q <= staged_nxt;
      if (go_wr && (staged_nxt != '0)) go_q <= 1'b1;
      else if (fire_ev)                go_q <= 1'b0;
    end
  end

endmodule

// File: rtl/syncpt_link_power.sv
module syncpt_link_power #(
  parameter int ACK_DELAY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_wr,
  input  logic req_din,
  output logic req_q,
  output logic ack_q
);

  localparam int CW = $clog2(ACK_DELAY + 1);

  logic [CW-1:0] wait_q;
  logic          pending;
  logic          expire;

  assign pending = (req_q != ack_q);
  assign expire  = pending && (wait_q == CW'(ACK_DELAY - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (req_wr) begin
      req_q <= req_din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      wait_q <= '0;
    end else if (!pending) begin
      wait_q <= '0;
    end else if (expire) begin
      ack_q  <= req_q;
      wait_q <= '0;
    end else begin
      wait_q <= wait_q + 1'b1;
    end
  end

endmodule

// File: rtl/sync_point_ctrl.sv
module sync_point_ctrl
  import syncpt_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int PERIOD_W  = 15,
  parameter int ACK_DELAY = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 sync_pulse,
  output logic [NUM_LINKS-1:0] bank_switch,
  output logic [NUM_LINKS-1:0] link_active
);

  localparam int STAGE_PAD = 8 - NUM_LINKS;

  logic                 wr_sync;
  logic                 wr_link;
  logic                 hs_wr;
  logic                 go_wr;
  logic [NUM_LINKS-1:0] stage_set;
  logic [PERIOD_W-1:0]  period_q;
  logic [PERIOD_W-1:0]  active_period;
  logic                 hs_q;
  logic                 commit_ev;
  logic [NUM_LINKS-1:0] staged_q;
  logic                 go_q;
  logic                 fire_ev;
  logic [NUM_LINKS-1:0] link_req;
  logic [NUM_LINKS-1:0] link_ack;

  assign wr_sync   = reg_wr && (reg_sel == SEL_SYNC);
  assign wr_link   = reg_wr && (reg_sel == SEL_LINK);
  assign hs_wr     = wr_sync && reg_wdata[HS_BIT];
  assign go_wr     = wr_sync && reg_wdata[GO_BIT];
  assign stage_set = wr_sync ? reg_wdata[STAGE_LSB +: NUM_LINKS] : '0;

  syncpt_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .hs_wr         (hs_wr),
    .wr_period     (reg_wdata[PERIOD_W-1:0]),
    .any_active    (|link_ack),
    .period_q      (period_q),
    .hs_q          (hs_q),
    .active_period (active_period),
    .sync_pulse    (sync_pulse),
    .commit_ev     (commit_ev)
  );

  syncpt_bank_stager #(.NUM_LINKS(NUM_LINKS)) u_stager (
    .clk         (clk),
    .rst_n       (rst_n),
    .stage_set   (stage_set),
    .go_wr       (go_wr),
    .sync_pulse  (sync_pulse),
    .staged_q    (staged_q),
    .go_q        (go_q),
    .bank_switch (bank_switch),
    .fire_ev     (fire_ev)
  );

  for (genvar n = 0; n < NUM_LINKS; n++) begin : g_link
    syncpt_link_power #(.ACK_DELAY(ACK_DELAY)) u_pwr (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_wr  (wr_link),
      .req_din (reg_wdata[n]),
      .req_q   (link_req[n]),
      .ack_q   (link_ack[n])
    );
  end

  assign link_active = link_ack;

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_SYNC) begin
      reg_rdata = pack_sync(32'(period_q), hs_q,
                            {{STAGE_PAD{1'b0}}, staged_q}, go_q);
    end else begin
      reg_rdata[NUM_LINKS-1:0]         = link_req;
      reg_rdata[ACK_LSB +: NUM_LINKS]  = link_ack;
    end
  end

endmodule

// File: rtl/syncpt_ctrl_chk.sv
module syncpt_ctrl_chk #(
  parameter int NUM_LINKS = 4,
  parameter int PERIOD_W  = 15
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic                 sync_pulse,
  input logic [NUM_LINKS-1:0] bank_switch,
  input logic                 hs_q,
  input logic [PERIOD_W-1:0]  active_period,
  input logic [NUM_LINKS-1:0] staged_q,
  input logic                 go_q,
  input logic                 commit_ev,
  input logic                 fire_ev,
  input logic [NUM_LINKS-1:0] link_req,
  input logic [NUM_LINKS-1:0] link_ack
);

  logic [PERIOD_W:0] gap_q;
  logic              gap_ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q    <= '0;
      gap_ok_q <= 1'b0;
    end else if (commit_ev) begin
      gap_q    <= '0;
      gap_ok_q <= 1'b0;
    end else if (sync_pulse) begin
      gap_q    <= '0;
      gap_ok_q <= 1'b1;
    end else begin
      gap_q    <= gap_q + 1'b1;
    end
  end

  // R2
  sync_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && gap_ok_q) |-> (gap_q == {1'b0, active_period}));

  // R4
  hs_clear_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_q) |-> ($past(link_ack) != '0));

  // R7
  switch_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_switch != '0) |-> sync_pulse);

  // R7
  launch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_ev && !reg_wr) |=> ((staged_q == '0) && !go_q));

  // R8
  go_needs_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> (staged_q != '0));

  // R9
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(link_ack) |->
      (((link_ack ^ $past(link_ack)) & (link_ack ^ $past(link_req))) == '0));

endmodule

bind sync_point_ctrl syncpt_ctrl_chk #(
  .NUM_LINKS (NUM_LINKS),
  .PERIOD_W  (PERIOD_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .sync_pulse    (sync_pulse),
  .bank_switch   (bank_switch),
  .hs_q          (hs_q),
  .active_period (active_period),
  .staged_q      (staged_q),
  .go_q          (go_q),
  .commit_ev     (commit_ev),
  .fire_ev       (fire_ev),
  .link_req      (link_req),
  .link_ack      (link_ack)
);

// File: tb/sync_point_ctrl_bench.sv
module sync_point_ctrl_bench;

  localparam int CLK_P = 10;
  localparam int NL    = 4;
  localparam int DLY   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_sel = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          sync_pulse;
  logic [NL-1:0] bank_switch;
  logic [NL-1:0] link_active;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  sync_point_ctrl u_sync_point_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .sync_pulse  (sync_pulse),
    .bank_switch (bank_switch),
    .link_active (link_active)
  );

  // bench restatement of the register layout
  function automatic logic [31:0] sync_word(input int p, input bit hs,
                                            input logic [3:0] stg, input bit go);
    return (32'(p) & 32'h7FFF) | (32'(hs) << 15) | (32'(stg) << 16) | (32'(go) << 24);
  endfunction

  function automatic int gap_for(input int p);
    return p + 1;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_pulse();
    while (!sync_pulse) @(negedge clk);
  endtask

  task automatic measure(output int n);
    wait_pulse();
    @(negedge clk);
    n = 1;
    while (!sync_pulse) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int          n;
    int          cur_p;
    logic [3:0]  req_m;

    $urandom(1234);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, d); chk(d == 32'h0, "R1 sync reg", d, 0);
    rd(1'b1, d); chk(d == 32'h0, "R1 link reg", d, 0);
    chk(bank_switch == 0 && link_active == 0, "R1 outputs",
        {bank_switch, link_active}, 0);
    n = 0;
    repeat (3) begin @(negedge clk); if (sync_pulse) n++; end
    chk(n == 3, "R1 sync every cycle", n, 3);

    // R3 period write without handshake ignored
    wr(1'b0, 32'h0000_0123);
    rd(1'b0, d); chk(d == 32'h0, "R3 no-handshake write", d, 0);

    // R3 period with handshake loads; R4 not applied while no link active
    wr(1'b0, sync_word(5, 1, 0, 0));
    rd(1'b0, d); chk(d == sync_word(5, 1, 0, 0), "R3 handshake write", d, sync_word(5, 1, 0, 0));
    n = 0;
    repeat (4) begin @(negedge clk); if (sync_pulse) n++; end
    chk(n == 4, "R4 old rate kept", n, 4);
    rd(1'b0, d); chk(d[15] == 1'b1, "R4 handshake pending", d[15], 1);

    // R9 link 0 power up, ack bit write ignored, exact delay
    wr(1'b1, 32'h0000_0101);
    rd(1'b1, d); chk(d == 32'h1, "R9 request only", d, 1);
    repeat (15) @(negedge clk);
    rd(1'b1, d); chk(d[8] == 1'b0, "R9 ack before delay", d[8], 0);
    @(negedge clk);
    rd(1'b1, d); chk(d[8] == 1'b1, "R9 ack after delay", d[8], 1);
    chk(link_active == 4'b0001, "R10 link_active", link_active, 1);
    req_m = 4'b0001;

    // R4 handshake cleared by hardware then new period applied
    @(negedge clk);
    rd(1'b0, d); chk(d[15] == 1'b0, "R4 handshake cleared", d[15], 0);
    measure(n); chk(n == gap_for(5), "R2 interval p=5", n, gap_for(5));
    cur_p = 5;

    // R3 later period write without handshake leaves period and rate
    wr(1'b0, 32'h0000_0007);
    rd(1'b0, d); chk(d[14:0] == 15'd5, "R3 period kept", d[14:0], 5);
    measure(n); chk(n == gap_for(5), "R3 rate kept", n, gap_for(5));

    // R8 go with nothing staged
    wr(1'b0, sync_word(0, 0, 0, 1));
    rd(1'b0, d); chk(d[24] == 1'b0, "R8 go reads zero", d[24], 0);
    n = 0;
    repeat (20) begin @(negedge clk); if (bank_switch != 0) n++; end
    chk(n == 0, "R8 no bank switch", n, 0);

    // R5 staging, R6 go, R7 launch
    wr(1'b0, sync_word(0, 0, 4'b0010, 0));
    wr(1'b0, sync_word(0, 0, 4'b1000, 0));
    rd(1'b0, d); chk(d[19:16] == 4'b1010, "R5 staged readback", d[19:16], 4'b1010);
    wr(1'b0, sync_word(0, 0, 0, 1));
    rd(1'b0, d); chk(d[24] == 1'b1, "R6 go set", d[24], 1);
    wait_pulse();
    chk(bank_switch == 4'b1010, "R7 launch mask", bank_switch, 4'b1010);
    @(negedge clk);
    chk(bank_switch == 0, "R7 one cycle", bank_switch, 0);
    rd(1'b0, d); chk(d[24:16] == 0, "R7 cleared", d[24:16], 0);

    // R11 request withdrawn before delay
    wr(1'b1, 32'h0000_0003);
    repeat (8) @(negedge clk);
    wr(1'b1, 32'h0000_0001);
    repeat (30) @(negedge clk);
    rd(1'b1, d); chk(d[9] == 1'b0, "R11 ack unchanged", d[9], 0);

    // random mix
    for (int it = 0; it < 8; it++) begin
      int         p;
      logic [3:0] m;
      int         l;
      p = 2 + int'($urandom % 20);
      wr(1'b0, sync_word(p, 1, 0, 0));
      repeat (2) @(negedge clk);
      rd(1'b0, d); chk(d[15] == 1'b0, "R4 random handshake", d[15], 0);
      measure(n); chk(n == gap_for(p), "R2 random interval", n, gap_for(p));
      measure(n); chk(n == gap_for(p), "R2 random interval 2", n, gap_for(p));

      m = 4'($urandom);
      wr(1'b0, sync_word(0, 0, m, 0));
      wr(1'b0, sync_word(0, 0, 0, 1));
      rd(1'b0, d); chk(d[24] == (m != 0), "R6 random go", d[24], (m != 0));
      if (m != 0) begin
        wait_pulse();
        chk(bank_switch == m, "R7 random launch", bank_switch, m);
        @(negedge clk);
        rd(1'b0, d); chk(d[19:16] == 0, "R7 random cleared", d[19:16], 0);
      end else begin
        chk(bank_switch == 0, "R8 random empty go", bank_switch, 0);
      end

      l = 1 + int'($urandom % 3);
      req_m[l] = ~req_m[l];
      wr(1'b1, 32'(req_m));
      repeat (15) @(negedge clk);
      chk(link_active[l] != req_m[l], "R9 random before", link_active[l], ~req_m[l]);
      @(negedge clk);
      chk(link_active[l] == req_m[l], "R9 random after", link_active[l], req_m[l]);
    end

    // R9 power down link 0
    req_m[0] = 1'b0;
    wr(1'b1, 32'(req_m));
    repeat (16) @(negedge clk);
    rd(1'b1, d); chk(d[8] == 1'b0, "R9 ack cleared", d[8], 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule